// File: doc/BRIEF.md
# CRC32C Checksum Accumulate, Store and Test Unit

This unit keeps a running CRC32C (Castagnoli) checksum over the source bytes of a stream of data-movement descriptors. A descriptor is presented for one cycle on `desc_start` together with its opcode, a seed-enable flag, a location flag, a 32-bit seed and a 32-bit reference value. The descriptor's bytes then arrive one per cycle on a valid/last handshake. The accumulator is not cleared between descriptors. A long buffer can therefore be checksummed across several descriptors, and only the first one needs to reload the seed.

The opcode selects one of three modes: accumulate only, store, or test. Each mode comes in two variants. The copy variant tells the surrounding engine, through `copy_en`, that the bytes are also being moved. The checksum-only variant does not. In store mode the finished value is presented in wire format, which means bitwise inverted while the register is kept in reflected bit order. In test mode the same wire-format value is compared with the reference. A mismatch raises a checksum error and halts the unit until reset. The location flag is latched and driven out on `loc_sel` so that neighbouring logic can decide where the reference is read from or where the result is written. This unit does no addressing itself.

Top module: `crc32c_unit`

## Requirements
- R1: Only opcodes 0x41, 0x42, 0x43 (copy variants) and 0x81, 0x82, 0x83 (checksum-only variants) start a descriptor. Opcode bits [1:0] select the mode: 1 accumulate, 2 test, 3 store. Bit 6 marks the copy variant. Any other opcode, and any `desc_start` while a descriptor is active, is ignored and leaves `active` unchanged.
- R2: Each accepted byte updates the accumulator by one step of the reflected polynomial 0x82F63B78, least-significant bit first. Exactly one byte is folded per cycle with `in_valid` high while `active`. Bytes offered while not active leave the accumulator unchanged.
- R3: When `desc_use_seed` is 1 at an accepted start, the accumulator is loaded with `desc_seed`. When it is 0, the accumulator keeps its value from the previous descriptor.
- R4: `done` pulses high for exactly one cycle, in the cycle after the byte that carried `in_last`. `active` is low in that same cycle.
- R5: In store mode, `result_valid` is high together with `done`, and `result` equals the bitwise inverse of the accumulator. Seeding with 0xFFFFFFFF and feeding ASCII "123456789" gives 0xE3069283.
- R6: In test mode, `chk_error` is high at `done` exactly when the inverted accumulator differs from `desc_ref`. `result_valid` stays low.
- R7: In accumulate-only mode neither `result_valid` nor `chk_error` is ever raised.
- R8: A checksum error sets `halted` in the same cycle as `done`. `halted` stays set until reset. While it is set, descriptor starts and bytes are ignored.
- R9: `loc_sel` and `copy_en` show the location flag and the copy variant of the last accepted descriptor. They are held from the cycle after its start until the next accepted start.
- R10: After reset the accumulator holds 0xFFFFFFFF, and `active`, `done`, `result`, `result_valid`, `chk_error`, `halted`, `loc_sel` and `copy_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_start | input | 1 | Descriptor fields valid this cycle |
| desc_opcode | input | 8 | Operation code |
| desc_use_seed | input | 1 | Load the accumulator from the seed |
| desc_loc | input | 1 | Location select for reference or result |
| desc_seed | input | 32 | Seed value |
| desc_ref | input | 32 | Reference checksum in wire format |
| in_valid | input | 1 | Source byte valid |
| in_data | input | 8 | Source byte |
| in_last | input | 1 | Final byte of the descriptor |
| active | output | 1 | A descriptor is consuming bytes |
| done | output | 1 | Descriptor finished (one-cycle pulse) |
| result | output | 32 | Wire-format checksum (store mode) |
| result_valid | output | 1 | `result` is valid this cycle |
| chk_error | output | 1 | Test-mode mismatch at done |
| halted | output | 1 | Sticky halt after a checksum error |
| loc_sel | output | 1 | Latched location flag |
| copy_en | output | 1 | Latched copy-variant flag |

## Verification
The assertions assume that each descriptor carries at least one byte, that `in_last` arrives on a valid byte, and that no byte comes in the same cycle as the start that opens its descriptor. Under these assumptions two `done` pulses are always at least two cycles apart. The stimulus keeps to them: every start is issued alone and followed by a non-empty burst that ends in `in_last`. Stray bytes and illegal starts are sent only while no descriptor is active, so they probe the ignore rules without breaking these input assumptions.

// File: rtl/crc32c_pkg.sv
package crc32c_pkg;

    localparam int          CRC_W     = 32;
    localparam int          BYTE_W    = 8;
    localparam int          OPC_W     = 8;
    localparam logic [CRC_W-1:0] POLY_REFL = 32'h82F63B78;
    localparam logic [CRC_W-1:0] ACC_INIT  = 32'hFFFFFFFF;

    typedef enum logic [1:0] {
        MODE_NONE  = 2'd0,
        MODE_ACCUM = 2'd1,
        MODE_TEST  = 2'd2,
        MODE_STORE = 2'd3
    } crc_mode_e;

    typedef struct packed {
        logic             copy;
        crc_mode_e        mode;
        logic             loc;
        logic [CRC_W-1:0] ref_val;
    } desc_ctx_t;

    // legal: exactly one of bits 7/6, bits 5:2 clear, mode nonzero
    function automatic logic opcode_legal(input logic [OPC_W-1:0] op);
        return (op[7] ^ op[6]) && (op[5:2] == 4'd0) && (op[1:0] != 2'd0);
    endfunction

    function automatic crc_mode_e opcode_mode(input logic [OPC_W-1:0] op);
        return crc_mode_e'(op[1:0]);
    endfunction

    function automatic logic [CRC_W-1:0] to_wire(input logic [CRC_W-1:0] acc);
        return ~acc;
    endfunction

endpackage

// File: rtl/crc32c_byte_step.sv
module crc32c_byte_step #(
    parameter int          CRC_W  = 32,
    parameter int          BYTE_W = 8,
    parameter logic [CRC_W-1:0] POLY = 32'h82F63B78
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [CRC_W-1:0]  crc_out
);
    logic [CRC_W-1:0] stage [BYTE_W+1];

    assign stage[0] = crc_in ^ {{(CRC_W-BYTE_W){1'b0}}, byte_in};

    for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
        assign stage[b+1] = stage[b][0] ? ((stage[b] >> 1) ^ POLY) : (stage[b] >> 1);
    end

    assign crc_out = stage[BYTE_W];
endmodule

// File: rtl/crc32c_desc_ctrl.sv
module crc32c_desc_ctrl
    import crc32c_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             desc_start,
    input  logic [OPC_W-1:0] desc_opcode,
    input  logic             desc_loc,
    input  logic [CRC_W-1:0] desc_ref,
    input  logic             last_fire,
    input  logic             mismatch,
    output logic             accept,
    output logic             active,
    output logic             halted,
    output desc_ctx_t        ctx
);
    assign accept = desc_start && !active && !halted && opcode_legal(desc_opcode);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            halted <= 1'b0;
            ctx    <= '0;
        end else begin
            if (accept) begin
                active      <= 1'b1;
                ctx.copy    <= desc_opcode[6];
                ctx.mode    <= opcode_mode(desc_opcode);
                ctx.loc     <= desc_loc;
                ctx.ref_val <= desc_ref;
            end else if (last_fire) begin
                active <= 1'b0;
            end
            if (mismatch) halted <= 1'b1;
        end
    end

    // R8: halt is sticky
    a_r8_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R1: illegal opcode never opens a descriptor
    a_r1_illegal_ignored: assert property (@(posedge clk) disable iff (rst)
        (desc_start && !active && !opcode_legal(desc_opcode)) |=> !active);

    // R8: halted unit never accepts
    a_r8_no_start_halted: assert property (@(posedge clk) disable iff (rst)
        (halted && !active) |=> !active);
endmodule

// File: rtl/crc32c_unit.sv
module crc32c_unit
    import crc32c_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              desc_start,
    input  logic [OPC_W-1:0]  desc_opcode,
    input  logic              desc_use_seed,
    input  logic              desc_loc,
    input  logic [CRC_W-1:0]  desc_seed,
    input  logic [CRC_W-1:0]  desc_ref,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    output logic              active,
    output logic              done,
    output logic [CRC_W-1:0]  result,
    output logic              result_valid,
    output logic              chk_error,
    output logic              halted,
    output logic              loc_sel,
    output logic              copy_en
);
    logic [CRC_W-1:0] acc_q;
    logic [CRC_W-1:0] acc_next;
    logic             accept;
    logic             byte_fire;
    logic             last_fire;
    logic             mismatch;
    desc_ctx_t        ctx;

    assign byte_fire = in_valid && active;
    assign last_fire = byte_fire && in_last;
    assign mismatch  = last_fire && (ctx.mode == MODE_TEST) &&
                       (to_wire(acc_next) != ctx.ref_val);

    crc32c_byte_step #(
        .CRC_W  (CRC_W),
        .BYTE_W (BYTE_W),
        .POLY   (POLY_REFL)
    ) step_i (
        .crc_in  (acc_q),
        .byte_in (in_data),
        .crc_out (acc_next)
    );

    crc32c_desc_ctrl ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .desc_start  (desc_start),
        .desc_opcode (desc_opcode),
        .desc_loc    (desc_loc),
        .desc_ref    (desc_ref),
        .last_fire   (last_fire),
        .mismatch    (mismatch),
        .accept      (accept),
        .active      (active),
        .halted      (halted),
        .ctx         (ctx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q        <= ACC_INIT;
            done         <= 1'b0;
            result       <= '0;
            result_valid <= 1'b0;
            chk_error    <= 1'b0;
        end else begin
            done         <= last_fire;
            result_valid <= last_fire && (ctx.mode == MODE_STORE);
            chk_error    <= mismatch;
            if (accept && desc_use_seed) begin
                acc_q <= desc_seed;
            end else if (byte_fire) begin
                acc_q <= acc_next;
            end
            if (last_fire && (ctx.mode == MODE_STORE)) begin
                result <= to_wire(acc_next);
            end
        end
    end

    assign loc_sel = ctx.loc;
    assign copy_en = ctx.copy;

    // R4: done follows the last byte, and is a single pulse
    a_r4_done_after_last: assert property (@(posedge clk) disable iff (rst)
        last_fire |=> (done && !active));
    a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3: seed load
    a_r3_seed_load: assert property (@(posedge clk) disable iff (rst)
        (accept && desc_use_seed) |=> (acc_q == $past(desc_seed)));

    // R5: store result only with done in store mode
    a_r5_store_valid: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> (done && ctx.mode == MODE_STORE));

    // R6: error only in test mode at done, and halts at once
    a_r6_err_test_only: assert property (@(posedge clk) disable iff (rst)
        chk_error |-> (done && ctx.mode == MODE_TEST && halted));

    // R7: accumulate-only never flags
    a_r7_accum_quiet: assert property (@(posedge clk) disable iff (rst)
        (done && ctx.mode == MODE_ACCUM) |-> (!chk_error && !result_valid));

    // R2: accumulator idle without an accepted byte or seed
    a_r2_acc_hold: assert property (@(posedge clk) disable iff (rst)
        (!active && !accept) |=> $stable(acc_q));
endmodule

// File: tb/crc32c_unit_tb.sv
`timescale 1ns/1ps
module crc32c_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        desc_start;
    logic [7:0]  desc_opcode;
    logic        desc_use_seed;
    logic        desc_loc;
    logic [31:0] desc_seed;
    logic [31:0] desc_ref;
    logic        in_valid;
    logic [7:0]  in_data;
    logic        in_last;
    logic        active;
    logic        done;
    logic [31:0] result;
    logic        result_valid;
    logic        chk_error;
    logic        halted;
    logic        loc_sel;
    logic        copy_en;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model_acc;

    always #2 clk = ~clk;

    crc32c_unit dut_i (
        .clk(clk), .rst(rst), .desc_start(desc_start), .desc_opcode(desc_opcode),
        .desc_use_seed(desc_use_seed), .desc_loc(desc_loc), .desc_seed(desc_seed),
        .desc_ref(desc_ref), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .active(active), .done(done), .result(result), .result_valid(result_valid),
        .chk_error(chk_error), .halted(halted), .loc_sel(loc_sel), .copy_en(copy_en)
    );

    typedef struct packed {
        logic [7:0]  op;
        logic        use_seed;
        logic [31:0] seed;
        logic        loc;
        logic [7:0]  base;
        logic [7:0]  len;
        logic [31:0] exp_res;  // 0 = take from model
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{8'h83, 1'b1, 32'hFFFFFFFF, 1'b0, 8'h31, 8'd9,  32'hE3069283},
        '{8'h81, 1'b1, 32'hFFFFFFFF, 1'b1, 8'h31, 8'd4,  32'h0},
        '{8'h43, 1'b0, 32'h0,        1'b1, 8'h35, 8'd5,  32'hE3069283},
        '{8'h42, 1'b1, 32'h12345678, 1'b1, 8'h00, 8'd16, 32'h0},
        '{8'h82, 1'b0, 32'h0,        1'b0, 8'hA0, 8'd1,  32'h0},
        '{8'h41, 1'b1, 32'h00000000, 1'b0, 8'h7F, 8'd3,  32'h0},
        '{8'h83, 1'b0, 32'h0,        1'b1, 8'hFE, 8'd2,  32'h0}
    };

    function automatic logic [31:0] model_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] x = c ^ {24'd0, b};
        for (int i = 0; i < 8; i++) x = x[0] ? ((x >> 1) ^ 32'h82F63B78) : (x >> 1);
        return x;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic start_desc(input logic [7:0] op, input logic us, input logic [31:0] seed,
                              input logic loc, input logic [31:0] refv);
        @(negedge clk);
        desc_start = 1'b1; desc_opcode = op; desc_use_seed = us;
        desc_seed = seed; desc_loc = loc; desc_ref = refv;
        @(negedge clk);
        desc_start = 1'b0;
    endtask

    // drives bytes from the current negedge; returns at the negedge after the last byte
    task automatic send_bytes(input logic [7:0] base, input int len);
        for (int k = 0; k < len; k++) begin
            in_valid = 1'b1; in_data = base + 8'(k); in_last = (k == len - 1);
            @(negedge clk);
        end
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    function automatic logic [31:0] model_run(input logic [31:0] st, input logic [7:0] base,
                                              input int len);
        logic [31:0] s = st;
        for (int k = 0; k < len; k++) s = model_step(s, base + 8'(k));
        return s;
    endfunction

    initial begin
        #(4 * 100000);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; desc_start = 0; desc_opcode = 0; desc_use_seed = 0; desc_loc = 0;
        desc_seed = 0; desc_ref = 0; in_valid = 0; in_data = 0; in_last = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk("R10 outputs", {26'd0, active, done, result_valid, chk_error, halted, loc_sel | copy_en}, 32'd0);
        chk("R10 result", result, 32'd0);
        model_acc = 32'hFFFFFFFF;

        // R1: illegal opcode ignored, R2: stray bytes ignored
        start_desc(8'h84, 1'b1, 32'h0BAD0BAD, 1'b1, 32'h0);
        chk("R1 illegal opcode", {31'd0, active}, 32'd0);
        send_bytes(8'h55, 3);
        chk("R2 stray bytes no done", {31'd0, done}, 32'd0);

        for (int v = 0; v < NV; v++) begin
            logic [31:0] refv;
            logic [31:0] fin;
            fin = model_run(VECS[v].use_seed ? VECS[v].seed : model_acc,
                            VECS[v].base, int'(VECS[v].len));
            refv = ~fin;
            start_desc(VECS[v].op, VECS[v].use_seed, VECS[v].seed, VECS[v].loc, refv);
            chk("R1 active", {31'd0, active}, 32'd1);
            chk("R9 loc/copy", {30'd0, loc_sel, copy_en}, {30'd0, VECS[v].loc, VECS[v].op[6]});
            send_bytes(VECS[v].base, int'(VECS[v].len));
            model_acc = fin;
            // R4: done at this cycle, active low
            chk("R4 done", {30'd0, done, active}, 32'd2);
            if (VECS[v].op[1:0] == 2'd3) begin
                chk("R5 store valid", {31'd0, result_valid}, 32'd1);
                chk("R5 store value R3", result, ~fin);
                if (VECS[v].exp_res != 32'h0) chk("R5 check value", result, VECS[v].exp_res);
            end else begin
                chk("R6 R7 no result_valid", {31'd0, result_valid}, 32'd0);
            end
            chk("R6 R7 no error", {31'd0, chk_error}, 32'd0);
            @(negedge clk);
            chk("R4 single pulse", {31'd0, done}, 32'd0);
            chk("R9 held", {30'd0, loc_sel, copy_en}, {30'd0, VECS[v].loc, VECS[v].op[6]});
        end

        // R2: bytes while idle leave accumulator alone; verified by an unseeded store
        send_bytes(8'h11, 4);
        start_desc(8'h83, 1'b0, 32'h0, 1'b0, 32'h0);
        send_bytes(8'h20, 2);
        model_acc = model_run(model_acc, 8'h20, 2);
        chk("R2 idle bytes ignored", result, ~model_acc);

        // R1: start during active descriptor ignored
        start_desc(8'h81, 1'b0, 32'h0, 1'b0, 32'h0);
        @(negedge clk);
        desc_start = 1'b1; desc_opcode = 8'h83; desc_use_seed = 1'b1; desc_seed = 32'h0; desc_loc = 1'b1;
        @(negedge clk);
        desc_start = 1'b0;
        chk("R1 start while active", {30'd0, loc_sel, copy_en}, 32'd0);
        send_bytes(8'h40, 2);
        model_acc = model_run(model_acc, 8'h40, 2);
        chk("R7 accum no result", {30'd0, result_valid, chk_error}, 32'd0);

        // R6/R8: mismatch in test mode
        start_desc(8'h82, 1'b1, 32'hFFFFFFFF, 1'b0,
                   (~model_run(32'hFFFFFFFF, 8'h31, 9)) ^ 32'h1);
        send_bytes(8'h31, 9);
        chk("R6 error at done", {29'd0, done, chk_error, result_valid}, 32'd6);
        chk("R8 halted with done", {31'd0, halted}, 32'd1);
        @(negedge clk);
        chk("R6 error pulse", {31'd0, chk_error}, 32'd0);
        start_desc(8'h83, 1'b1, 32'h0, 1'b1, 32'h0);
        chk("R8 start ignored", {31'd0, active}, 32'd0);
        send_bytes(8'h00, 2);
        chk("R8 no done halted", {30'd0, done, halted}, 32'd1);

        // R10: reset clears halt
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 halt cleared", {30'd0, halted, active}, 32'd0);
        // R10: accumulator back to all ones
        start_desc(8'h83, 1'b0, 32'h0, 1'b0, 32'h0);
        send_bytes(8'h31, 9);
        chk("R10 acc reset value", result, 32'hE3069283);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule